// File: doc/BRIEF.md
# Double-Buffered Phase-Accumulator PWM

This block produces a single pulse-width-modulated output. It is configured through one 32-bit register with a single-cycle write strobe and a combinational read port. The output frequency comes from a phase accumulator. Each clock the accumulator adds a programmable increment, and a carry out of its top bit ends one output period. The duty is set by an 8-bit threshold that is stored inverted. The output is high while the accumulator's top eight bits are at or above that threshold.

Software writes new settings into a readable shadow copy. A new setting reaches the output only when the write also sets the update request bit. That write copies the fields into a staging set and marks a request as pending. At the next period boundary the hardware moves the staged set into the active set and clears the request bit. While a request is pending, further writes still change the readable shadow copy, but they cannot alter the staged set. While the output is disabled every clock counts as a period boundary, so a pending request completes on the next clock.

Top module: `pwm_dbuf_top`

## Requirements
- R1: After reset the register reads 0 and the output is low. The active set resets to increment 1 and threshold 255. Enabling without an update request therefore keeps the output low for at least 600 cycles.
- R2: A write without bit 30 set has these effects: bit 31 becomes the enable, the increment field (bits 8 upward, INC_W wide) and the threshold field (bits 7:0) read back at once, and the output waveform does not change.
- R3: A write with bit 30 set while no request is pending makes bit 30 read 1 from the next cycle on. The bit clears at the clock edge where the accumulator carries out, and the staged fields become active at that same edge.
- R4: In every cycle the output equals enable AND (accumulator bits [INC_W-1:INC_W-8] >= active threshold). A threshold of 0 gives an output that is always high. A threshold of 255 gives the shortest on-time.
- R5: The accumulator wraps modulo 2^INC_W. When the increment divides 2^INC_W, the output period is exactly 2^INC_W / increment cycles.
- R6: While a request is pending, any further write (including one with bit 30 set) updates only the readable shadow fields. The set that becomes active is the one staged by the first request.
- R7: While the enable is 0 the output is low and bit 31 reads 0.
- R8: While disabled the accumulator is held at zero. After enabling, the first period starts from zero and has full length.
- R9: While disabled, a pending request completes on the next clock edge.
- R10: An increment of 0 is made active as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data: enable, pending request, shadow fields |
| pwm_o | output | 1 | PWM output |

## Verification
The bench sweeps all 256 threshold values at a 16-cycle period and counts the high cycles in each period. A comparator that is off by one at the boundary, or whose threshold is not inverted, shows up as a wrong count. A second request written while the first is still pending must not replace the staged values; a design that re-staged on it would give the wrong duty after the commit. The bench checks that the first period after enabling is full length and that a request completes at once while disabled; a design that kept a stale accumulator phase or waited for a carry would shift or stall the waveform. A zero increment must be made active as one; without that the accumulator would freeze and the output would never rise.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int REG_W   = 32;
  localparam int EN_BIT  = 31;
  localparam int UPD_BIT = 30;
  localparam int INC_LSB = 8;
  localparam int DIV_W   = 8;
  typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/pwm_dbuf_cfg.sv
module pwm_dbuf_cfg
  import pwm_dbuf_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             cycle_start_i,
  output logic             en_o,
  output logic [INC_W-1:0] act_inc_o,
  output div_t             act_div_o,
  output logic [REG_W-1:0] rd_data_o
);
  localparam logic [INC_W-1:0] INC_ONE = {{(INC_W-1){1'b0}}, 1'b1};

  logic             en_q, pend_q;
  logic [INC_W-1:0] sh_inc_q, stg_inc_q, act_inc_q;
  div_t             sh_div_q, stg_div_q, act_div_q;
  logic [INC_W-1:0] w_inc;
  div_t             w_div;
  logic             take_req, commit;

  assign w_inc    = wr_data_i[INC_LSB +: INC_W];
  assign w_div    = wr_data_i[DIV_W-1:0];
  assign take_req = wr_en_i & wr_data_i[UPD_BIT] & ~pend_q;
  assign commit   = pend_q & cycle_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      pend_q    <= 1'b0;
      sh_inc_q  <= '0;
      sh_div_q  <= '0;
      stg_inc_q <= '0;
      stg_div_q <= '0;
      act_inc_q <= INC_ONE;
      act_div_q <= '1;
    end else begin
      if (wr_en_i) begin
        en_q     <= wr_data_i[EN_BIT];
        sh_inc_q <= w_inc;
        sh_div_q <= w_div;
      end
      if (take_req) begin
        pend_q    <= 1'b1;
        stg_inc_q <= w_inc;
        stg_div_q <= w_div;
      end else if (commit) begin
        pend_q    <= 1'b0;
        act_inc_q <= (stg_inc_q == '0) ? INC_ONE : stg_inc_q;
        act_div_q <= stg_div_q;
      end
    end
  end

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[EN_BIT]              = en_q;
    rd_data_o[UPD_BIT]             = pend_q;
    rd_data_o[INC_LSB +: INC_W]    = sh_inc_q;
    rd_data_o[DIV_W-1:0]           = sh_div_q;
  end

  assign en_o      = en_q;
  assign act_inc_o = act_inc_q;
  assign act_div_o = act_div_q;

  assert_req_sets_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[UPD_BIT] && !pend_q |=> pend_q);
  assert_commit_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && cycle_start_i |=> !pend_q);
  assert_stage_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> $stable(stg_inc_q) && $stable(stg_div_q));
  assert_active_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q && cycle_start_i) |=> $stable(act_inc_q) && $stable(act_div_q));
  assert_inc_nonzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_inc_q != '0);
endmodule

// File: rtl/pwm_dbuf_acc.sv
module pwm_dbuf_acc #(
  parameter int INC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [INC_W-1:0] acc_o,
  output logic             wrap_o
);
  logic [INC_W-1:0] acc_q;
  logic [INC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, inc_i};
  assign wrap_o = en_i & sum[INC_W];
  assign acc_o  = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (!en_i) acc_q <= '0;
    else            acc_q <= sum[INC_W-1:0];
  end

  assert_acc_idle_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> acc_q == '0);
  assert_wrap_lowers_acc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> acc_q < $past(acc_q));
endmodule

// File: rtl/pwm_dbuf_cmp.sv
module pwm_dbuf_cmp
  import pwm_dbuf_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic             en_i,
  input  logic [INC_W-1:0] acc_i,
  input  div_t             div_i,
  output logic             pwm_o
);
  div_t top;
  assign top   = acc_i[INC_W-1 -: DIV_W];
  assign pwm_o = en_i & (top >= div_i);
endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top
  import pwm_dbuf_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        pwm_o
);
  logic             en;
  logic             wrap;
  logic [INC_W-1:0] act_inc, acc;
  div_t             act_div;

  // disabled: every clock is a boundary, so pending requests land at once
  logic cycle_start;
  assign cycle_start = ~en | wrap;

  pwm_dbuf_cfg #(.INC_W(INC_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .cycle_start_i(cycle_start),
    .en_o(en), .act_inc_o(act_inc), .act_div_o(act_div),
    .rd_data_o
  );

  pwm_dbuf_acc #(.INC_W(INC_W)) u_acc (
    .clk_i, .rst_ni, .en_i(en), .inc_i(act_inc), .acc_o(acc), .wrap_o(wrap)
  );

  pwm_dbuf_cmp #(.INC_W(INC_W)) u_cmp (
    .en_i(en), .acc_i(acc), .div_i(act_div), .pwm_o
  );

  assert_off_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[EN_BIT] |-> !pwm_o);
  assert_full_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && act_div == '0 |-> pwm_o);
endmodule

// File: tb/sim_pwm_dbuf_top.sv
module sim_pwm_dbuf_top;
  localparam int CLK_PERIOD = 10;
  localparam int INC_W      = 16;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        pwm;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dbuf_top #(.INC_W(INC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .pwm_o(pwm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit en, input bit upd, input int inc, input int dv);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = {en, upd, 6'b0, inc[15:0], dv[7:0]};
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic wait_clear();
    while (rd_data[30]) @(negedge clk);
  endtask

  task automatic count16(output int c);
    c = 0;
    for (int i = 0; i < 16; i++) begin
      c += int'(pwm);
      if (i < 15) @(negedge clk);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int c;
    rst_ni = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset readback", rd_data, 32'h0);
    chk("R1 reset output", {31'b0, pwm}, 32'h0);

    // R1: active set after reset gives minimum on-time
    wr(1, 0, 0, 0);
    chk("R1 enable readback", rd_data, 32'h8000_0000);
    for (int i = 0; i < 600; i++) begin
      chk("R1 reset active set low", {31'b0, pwm}, 32'h0);
      @(negedge clk);
    end
    wr(0, 0, 0, 0);

    // R9: commit while disabled lands on the next edge
    wr(0, 1, 4096, 255);
    chk("R9 pending set", {31'b0, rd_data[30]}, 32'h1);
    @(negedge clk);
    chk("R9 pending cleared while off", {31'b0, rd_data[30]}, 32'h0);

    // R4/R3: exhaustive threshold sweep, 16-cycle period
    for (int d = 0; d < 256; d++) begin
      wr(1, 1, 4096, d);
      chk("R3 pending after request", {31'b0, rd_data[30]}, 32'h1);
      wait_clear();
      count16(c);
      chk("R4 high cycles per period", c, 16 - (d + 15) / 16);
    end

    // R5: period 8, threshold 128
    wr(1, 1, 8192, 128);
    wait_clear();
    for (int i = 0; i < 16; i++) begin
      chk("R5 period-8 pattern", {31'b0, pwm}, {31'b0, (i % 8) >= 4});
      @(negedge clk);
    end

    // R2: write without request shows at once but leaves the waveform
    wr(1, 0, 4096, 0);
    chk("R2 readback", rd_data, 32'h8010_0000);
    count16(c);
    chk("R2 waveform unchanged", c, 8);

    // R6: second request while pending must not restage
    wr(1, 1, 4096, 64);
    wr(1, 1, 4096, 192);
    chk("R6 shadow shows later write", {24'b0, rd_data[7:0]}, 32'd192);
    wait_clear();
    count16(c);
    chk("R6 first staged set active", c, 12);

    // R7: disable
    wr(0, 0, 4096, 64);
    chk("R7 enable reads 0", {31'b0, rd_data[31]}, 32'h0);
    for (int i = 0; i < 40; i++) begin
      chk("R7 output low when off", {31'b0, pwm}, 32'h0);
      @(negedge clk);
    end

    // R9 again, then R8: full first period after enabling
    wr(0, 1, 4096, 128);
    chk("R9 pending set", {31'b0, rd_data[30]}, 32'h1);
    @(negedge clk);
    chk("R9 pending cleared", {31'b0, rd_data[30]}, 32'h0);
    wr(1, 0, 4096, 128);
    for (int i = 0; i < 16; i++) begin
      chk("R8 first period from zero", {31'b0, pwm}, {31'b0, i >= 8});
      @(negedge clk);
    end

    // R10: zero increment acts as one
    wr(0, 0, 0, 1);
    wr(0, 1, 0, 1);
    @(negedge clk);
    wr(1, 0, 0, 1);
    for (int i = 0; i < 300; i++) begin
      chk("R10 zero increment clamped", {31'b0, pwm}, {31'b0, i >= 256});
      @(negedge clk);
    end

    done = 1;
    report();
    $finish;
  end
endmodule